// File: doc/BRIEF.md
# Strapped Host Strobe and Acknowledge Controller

This block sits between an external host's asynchronous control pins and the packing logic of a host port. It brings in two active-low space selects (memory and I/O), an address strobe, a read strobe and a write strobe, and drives the host's acknowledge line. Every pin passes through a synchroniser into the peripheral clock domain. The block turns edges on these pins into one-cycle pulses: address latched, write data phase, read data phase, and access aborted.

Reset-time pin levels configure the block. After reset is released, it keeps watching the pins for a fixed window of peripheral cycles. From that window it learns four things: whether the address strobe is an active-high latch enable or an active-low address-cycle qualifier, the idle level (and therefore the polarity) of each data strobe, the acknowledge polarity, and the starting acknowledge style. The acknowledge line works in one of two styles. In handshake style it goes active once an access may finish. In ready style it drops to insert wait states. Software can read the sensed settings and can rewrite the acknowledge style.

Top module: `host_strobe_ack`

## Requirements
- R1: During the window of SENSE_CYCLES clocks after reset is released, the synchronised pin levels are captured. Afterwards, cfg_bits holds them: bit 0 is the read strobe idle level, bit 1 is the write strobe idle level, bit 2 is the address style (0 = active-high latch enable, 1 = active-low cycle qualifier, equal to the address pin level), bit 3 is the acknowledge polarity (1 = active-high, equal to the polarity pin level), and bits 5:4 are the acknowledge style.
- R2: The initial acknowledge style is 01 (ready) when the polarity pin and the acknowledge pin had equal levels, and 00 (handshake) when they differed.
- R3: While reset is held and throughout the sensing window, ack_oe is 0 and no event pulse is produced.
- R4: In latch-enable style, an address event is produced on a high-to-low edge of the address pin. This happens only while exactly one select is low and the write strobe was idle both before and after the edge. addr_io is 1 when the I/O select is the active one.
- R5: In cycle-qualifier style, an address event is produced on the trailing edge of the write strobe when the address pin was low and exactly one select is low.
- R6: In handshake style (00), the acknowledge is inactive while no strobe is active. It becomes active during a strobe once acc_ready is high, stays active until the strobe is released even if acc_ready falls, and then returns to inactive.
- R7: In ready style (01), the acknowledge is active while idle. It becomes inactive at the start of a strobe while acc_ready is low, and active again when acc_ready rises.
- R8: In cycle-qualifier style, the acknowledge goes active during an address cycle whatever the value of acc_ready.
- R9: With neither select low or with both selects low, no address, read or write event is produced.
- R10: When the active select is released, an abort event is produced.
- R11: A write event is produced on the trailing edge of the write strobe when the edge is not an address cycle. A read event is produced on the leading edge of the read strobe. Both require exactly one select low.
- R12: After the window, a pulse on mode_we loads mode_wd into the acknowledge style when mode_wd is 00 or 01. The reserved values 10 and 11 leave it unchanged.
- R13: The acknowledge pin level equals the polarity bit when the acknowledge is active, and its inverse when inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_mem_n | input | 1 | Memory/boot space select, active low |
| sel_io_n | input | 1 | I/O space select, active low |
| ale_pin | input | 1 | Host address strobe pin |
| rd_pin | input | 1 | Host read strobe pin |
| wr_pin | input | 1 | Host write strobe pin |
| ack_pol_pin | input | 1 | Acknowledge polarity strap pin |
| ack_in | input | 1 | Level seen on the acknowledge pin (strap) |
| acc_ready | input | 1 | Internal side can complete the current access |
| mode_we | input | 1 | Software write strobe for the acknowledge style |
| mode_wd | input | 2 | New acknowledge style value |
| ack_out | output | 1 | Acknowledge pin drive level |
| ack_oe | output | 1 | Acknowledge pin output enable |
| addr_evt | output | 1 | Address latch pulse |
| addr_io | output | 1 | I/O select active (valid with addr_evt) |
| wr_evt | output | 1 | Write data phase pulse |
| rd_evt | output | 1 | Read data phase pulse |
| abort_evt | output | 1 | Select released pulse |
| cfg_bits | output | 6 | Sensed and programmable mode bits |

## Verification
The bench builds the block with SYNC_STAGES = 2 and SENSE_CYCLES = 10. With these values a complete strap window plus the synchroniser latency is only a dozen cycles, so the bench can reset four times, once for each combination of polarity and acknowledge strap, and cover both address styles and both strobe polarities in one run. The two-stage chain gives every pin change a fixed delay of two clocks before it is seen. This lets the scoreboard match event pulses to the stimulus that caused them, in order, and flag any stray pulse.

// File: rtl/host_strobe_ack.sv
module host_strobe_ack #(
  parameter int SYNC_STAGES  = 2,
  parameter int SENSE_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_mem_n,
  input  logic       sel_io_n,
  input  logic       ale_pin,
  input  logic       rd_pin,
  input  logic       wr_pin,
  input  logic       ack_pol_pin,
  input  logic       ack_in,
  input  logic       acc_ready,
  input  logic       mode_we,
  input  logic [1:0] mode_wd,
  output logic       ack_out,
  output logic       ack_oe,
  output logic       addr_evt,
  output logic       addr_io,
  output logic       wr_evt,
  output logic       rd_evt,
  output logic       abort_evt,
  output logic [5:0] cfg_bits
);
  localparam int             CW   = $clog2(SENSE_CYCLES + 1);
  localparam logic [CW-1:0]  LAST = CW'(SENSE_CYCLES);

  // bit order: 6 ack strap, 5 polarity strap, 4 io sel, 3 mem sel, 2 wr, 1 rd, 0 ale
  logic [6:0] pins;
  logic [6:0] sy [SYNC_STAGES];
  logic [6:0] s;
  logic [4:0] q;
  assign pins = {ack_in, ack_pol_pin, sel_io_n, sel_mem_n, wr_pin, rd_pin, ale_pin};
  assign s    = sy[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= '0;
      q <= '0;
    end else begin
      sy[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
      q <= s[4:0];
    end
  end

  logic [CW-1:0] cnt;
  logic          sensing;
  assign sensing = (cnt != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (sensing) cnt <= cnt + 1'b1;
  end

  logic       rd_idle, wr_idle, ale_cyc, ack_hi;
  logic [1:0] mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idle <= 1'b0;
      wr_idle <= 1'b0;
      ale_cyc <= 1'b0;
      ack_hi  <= 1'b0;
      mode    <= 2'b00;
    end else if (sensing) begin
      rd_idle <= s[1];
      wr_idle <= s[2];
      ale_cyc <= s[0];
      ack_hi  <= s[5];
      mode    <= {1'b0, s[5] ~^ s[6]};
    end else if (mode_we && !mode_wd[1]) begin
      mode    <= mode_wd;
    end
  end

  assign cfg_bits = {mode, ack_hi, ale_cyc, wr_idle, rd_idle};

  logic live, sel_now, sel_was, rd_now, rd_was, wr_now, wr_was, ale_now, ale_was;
  assign live    = !sensing;
  assign sel_now = s[3] ^ s[4];
  assign sel_was = q[3] ^ q[4];
  assign rd_now  = s[1] ^ rd_idle;
  assign rd_was  = q[1] ^ rd_idle;
  assign wr_now  = s[2] ^ wr_idle;
  assign wr_was  = q[2] ^ wr_idle;
  assign ale_now = s[0] ^ ale_cyc;
  assign ale_was = q[0] ^ ale_cyc;

  logic latch_addr, cycle_addr;
  assign latch_addr = !ale_cyc && ale_was && !ale_now && !wr_now && !wr_was;
  assign cycle_addr =  ale_cyc && ale_was && wr_was && !wr_now;

  assign addr_evt  = live && sel_now && (latch_addr || cycle_addr);
  assign addr_io   = !s[4];
  assign wr_evt    = live && sel_now && wr_was && !wr_now && !(ale_cyc && ale_was);
  assign rd_evt    = live && sel_now && rd_now && !rd_was;
  assign abort_evt = live && sel_was && !sel_now;

  logic strobe_on, strobe_was, addr_phase, can_go, ack_q, ack_nx;
  assign strobe_on  = sel_now && (rd_now || wr_now);
  assign strobe_was = sel_was && (rd_was || wr_was);
  assign addr_phase = ale_cyc && sel_now && ale_now && wr_now;
  assign can_go     = addr_phase || acc_ready;
  assign ack_nx     = mode[0] ? (!strobe_on || can_go || (ack_q && strobe_was))
                              : (strobe_on && (can_go || (ack_q && strobe_was)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      ack_oe <= 1'b0;
    end else begin
      ack_q  <= live && ack_nx;
      ack_oe <= live;
    end
  end

  assign ack_out = ack_q ~^ ack_hi;

  a_r3_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    sensing |-> (!ack_oe && !(addr_evt || wr_evt || rd_evt || abort_evt)));

  a_r12_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1]);

  a_r8_addr_cycle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (live && addr_phase) |=> ack_q);

  a_r6_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode == 2'b00 && ack_q && strobe_on && strobe_was) |=> ack_q);

  a_r6_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !strobe_on) |=> !ack_q);

  a_r7_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode == 2'b01 && !strobe_on) |=> ack_q);
endmodule

// File: tb/test_host_strobe_ack.sv
module test_host_strobe_ack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_mem_n = 1'b1, sel_io_n = 1'b1;
  logic ale_pin = 1'b0, rd_pin = 1'b1, wr_pin = 1'b1;
  logic ack_pol_pin = 1'b1, ack_in = 1'b1, acc_ready = 1'b0;
  logic mode_we = 1'b0;
  logic [1:0] mode_wd = 2'b00;
  logic ack_out, ack_oe, addr_evt, addr_io, wr_evt, rd_evt, abort_evt;
  logic [5:0] cfg_bits;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit e_rd_idle, e_wr_idle, e_ale_cyc;
  int    q_kind[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  host_strobe_ack #(.SYNC_STAGES(2), .SENSE_CYCLES(10)) i_host_strobe_ack (
    .clk(clk), .rst_n(rst_n), .sel_mem_n(sel_mem_n), .sel_io_n(sel_io_n),
    .ale_pin(ale_pin), .rd_pin(rd_pin), .wr_pin(wr_pin),
    .ack_pol_pin(ack_pol_pin), .ack_in(ack_in), .acc_ready(acc_ready),
    .mode_we(mode_we), .mode_wd(mode_wd), .ack_out(ack_out), .ack_oe(ack_oe),
    .addr_evt(addr_evt), .addr_io(addr_io), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .abort_evt(abort_evt), .cfg_bits(cfg_bits));

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 addr mem, 1 addr io, 2 write, 3 read, 4 abort
  task automatic expect_evt(int kind, string tag);
    q_kind.push_back(kind);
    q_tag.push_back(tag);
  endtask

  task automatic set_rd(bit on);  rd_pin  = on ^ e_rd_idle;  endtask
  task automatic set_wr(bit on);  wr_pin  = on ^ e_wr_idle;  endtask
  task automatic set_ale(bit on); ale_pin = on ^ e_ale_cyc; endtask

  task automatic strap_reset(bit ale, bit rd, bit wr, bit pol, bit ak, int cfg_exp);
    @(negedge clk);
    sel_mem_n = 1'b1; sel_io_n = 1'b1; acc_ready = 1'b0;
    ale_pin = ale; rd_pin = rd; wr_pin = wr; ack_pol_pin = pol; ack_in = ak;
    e_ale_cyc = ale; e_rd_idle = rd; e_wr_idle = wr;
    rst_n = 1'b0;
    cyc(3);
    check("R3 oe in reset", ack_oe, 0);
    rst_n = 1'b1;
    cyc(4);
    check("R3 oe in window", ack_oe, 0);
    cyc(12);
    check("R1 R2 cfg", cfg_bits, cfg_exp);
    check("R3 oe after window", ack_oe, 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int cnt;
      int kind;
      cnt = int'(addr_evt) + int'(wr_evt) + int'(rd_evt) + int'(abort_evt);
      kind = addr_evt ? (addr_io ? 1 : 0) : wr_evt ? 2 : rd_evt ? 3 : 4;
      if (cnt > 1) check("R9 R11 overlapping events", cnt, 1);
      else if (cnt == 1) begin
        if (q_kind.size() == 0) check("R9 stray event", kind, 99);
        else begin
          int exp_k;
          string t;
          exp_k = q_kind.pop_front();
          t = q_tag.pop_front();
          check(t, kind, exp_k);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // Phase 1: latch-enable style, low-active strobes, high ack, ready style
    strap_reset(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'h1B);
    check("R7 R13 idle ready high", ack_out, 1);
    sel_mem_n = 1'b0; cyc(3);
    expect_evt(0, "R4 latch addr mem");
    set_ale(1); cyc(3); set_ale(0); cyc(4);
    expect_evt(3, "R11 read lead edge");
    set_rd(1); cyc(5);
    check("R7 wait state", ack_out, 0);
    acc_ready = 1'b1; cyc(4);
    check("R7 ready again", ack_out, 1);
    set_rd(0); cyc(3);
    set_wr(1); cyc(3);
    expect_evt(2, "R11 write trail edge");
    set_wr(0); cyc(4);
    expect_evt(4, "R10 deselect abort");
    sel_mem_n = 1'b1; cyc(4);
    set_ale(1); cyc(3); set_ale(0); cyc(4);
    sel_mem_n = 1'b0; sel_io_n = 1'b0; cyc(3);
    set_ale(1); cyc(3); set_ale(0); cyc(3);
    set_rd(1); cyc(3); set_rd(0); cyc(3);
    sel_mem_n = 1'b1; sel_io_n = 1'b1; cyc(4);
    check("R9 no events queued", q_kind.size(), 0);
    sel_io_n = 1'b0; cyc(3);
    expect_evt(1, "R4 latch addr io");
    set_ale(1); cyc(3); set_ale(0); cyc(4);
    expect_evt(4, "R10 io abort");
    sel_io_n = 1'b1; cyc(4);
    mode_we = 1'b1; mode_wd = 2'b10; cyc(1); mode_we = 1'b0; cyc(2);
    check("R12 reserved ignored", cfg_bits[5:4], 1);
    mode_we = 1'b1; mode_wd = 2'b00; cyc(1); mode_we = 1'b0; cyc(3);
    check("R12 style written", cfg_bits[5:4], 0);
    check("R6 idle inactive", ack_out, 0);
    sel_mem_n = 1'b0; acc_ready = 1'b1; cyc(3);
    expect_evt(3, "R11 read in handshake");
    set_rd(1); cyc(5);
    check("R6 ack active", ack_out, 1);
    acc_ready = 1'b0; cyc(4);
    check("R6 ack held", ack_out, 1);
    set_rd(0); cyc(4);
    check("R6 ack released", ack_out, 0);
    expect_evt(4, "R10 abort");
    sel_mem_n = 1'b1; cyc(4);

    // Phase 2: cycle-qualifier style, high-active strobes, low ack, handshake
    strap_reset(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'h04);
    check("R6 R13 idle pin high", ack_out, 1);
    sel_io_n = 1'b0; acc_ready = 1'b0; cyc(3);
    set_ale(1); set_wr(1); cyc(5);
    check("R8 addr cycle ack", ack_out, 0);
    expect_evt(1, "R5 cycle addr io");
    set_wr(0); cyc(3); set_ale(0); cyc(3);
    set_wr(1); cyc(5);
    check("R6 wait for ready", ack_out, 1);
    acc_ready = 1'b1; cyc(4);
    check("R6 R13 ack low active", ack_out, 0);
    expect_evt(2, "R11 write data cycle style");
    set_wr(0); cyc(4);
    expect_evt(3, "R11 read cycle style");
    set_rd(1); cyc(4); set_rd(0); cyc(3);
    expect_evt(4, "R10 abort");
    sel_io_n = 1'b1; cyc(4);

    // Phase 3: equal straps low -> ready, low ack
    strap_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'h13);
    check("R2 R13 ready idle low pin", ack_out, 0);

    // Phase 4: polarity 1, ack 0 -> handshake; write held during address strobe
    strap_reset(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'h0B);
    check("R2 handshake idle", ack_out, 0);
    sel_mem_n = 1'b0; cyc(3);
    set_wr(1); cyc(3); set_ale(1); cyc(3); set_ale(0); cyc(3);
    expect_evt(2, "R4 no addr with write active");
    set_wr(0); cyc(4);
    expect_evt(4, "R10 abort");
    sel_mem_n = 1'b1; cyc(4);
    check("R9 R11 all events seen", q_kind.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule